// File: doc/BRIEF.md
# Masked-Write Split GPIO Controller

This block controls 32 general-purpose pins through a simple register bus. The pins are split into a low half (pins 15:0) and a high half (pins 31:16). Each half has its own direction register and its own output-value register. The block drives the pad output enables and pad output values, and it offers a read-only register that returns the pin levels after synchronization.

Every write to a direction or output register carries two fields. Bits 31:16 are a per-bit enable mask and bits 15:0 are the new data. Only the bits whose mask bit is set take the new value. Software can therefore set or clear single pins in one bus write, with no read-modify-write and no race against another agent that updates other pins of the same half.

The bus is single-cycle. A write is taken on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_split_ctrl`

## Requirements
- R1: After reset, every direction bit and every output bit is 0, so `pad_oe` and `pad_out` are all zero.
- R2: A write to the output registers (low half at 0x100, high half at 0x104) or to the direction registers (low half at 0x108, high half at 0x10C) updates register bit i from write bit i only when write bit 16+i is 1. All other bits keep their value. The new value is in effect from the clock edge that takes the write.
- R3: A write whose mask field, bits 31:16, is all zero leaves the addressed register unchanged.
- R4: The low-half registers control only pins 15:0 and the high-half registers control only pins 31:16. A write to one half never changes the other half.
- R5: A direction bit of 1 makes its pin an output: `pad_oe` equals the two direction registers concatenated, high half above low half. `pad_out` bit i equals output bit i when direction bit i is 1, and is 0 otherwise.
- R6: Reading a direction or output register returns its 16-bit state in bits 15:0 and zeros in bits 31:16.
- R7: Reading the input register at 0x010 returns `pad_in` through two flip-flops. A pin change made before clock edge n is read back after edge n+1, and the old value is still read back between edges n and n+1.
- R8: A write to the input register or to any unmapped address changes no register. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data: mask in bits 31:16, value in bits 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Pin levels from the pads, asynchronous |
| pad_oe | output | 32 | Pad output enables |
| pad_out | output | 32 | Pad output values, gated by direction |

## Verification
A register write takes effect on the edge that samples it. The bench drives each write half a cycle before that edge and checks the register read-back and the `pad_oe`/`pad_out` pins half a cycle after it. Reads are combinational, so each read is sampled one time step after its address is set, with no clock edge in between. For the input path, the bench changes `pad_in` between edges and reads at two points: after the first edge it expects the old level, and after the second edge it expects the new level.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
    localparam logic [11:0] OFS_OUT_LO = 12'h100;
    localparam logic [11:0] OFS_OUT_HI = 12'h104;
    localparam logic [11:0] OFS_DIR_LO = 12'h108;
    localparam logic [11:0] OFS_DIR_HI = 12'h10C;
    localparam logic [11:0] OFS_PINS   = 12'h010;
    localparam int          HALF_STEP  = 4;
endpackage

// File: rtl/gpio_half_bank.sv
module gpio_half_bank #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_we,
    input  logic              out_we,
    input  logic [HALF_W-1:0] wmask,
    input  logic [HALF_W-1:0] wval,
    output logic [HALF_W-1:0] dir_q,
    output logic [HALF_W-1:0] out_q
);
    logic [HALF_W-1:0] dir_nx;
    logic [HALF_W-1:0] out_nx;

    always_comb begin
        dir_nx = dir_we ? ((dir_q & ~wmask) | (wval & wmask)) : dir_q;
        out_nx = out_we ? ((out_q & ~wmask) | (wval & wmask)) : out_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            dir_q <= dir_nx;
            out_q <= out_nx;
        end
    end

    // R2: bits outside the mask keep their value
    assert_dir_unmasked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> (((dir_q ^ $past(dir_q)) & ~$past(wmask)) == '0));
    assert_out_unmasked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0));
    // R3: an empty mask leaves the register as it was
    assert_zero_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_we || out_we) && wmask == '0) |=> ($stable(dir_q) && $stable(out_q)));
    // R8: with no write strobe the registers keep their value
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_we && !out_we) |=> ($stable(dir_q) && $stable(out_q)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [1:0]   fill_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             fill_cnt <= '0;
        else if (fill_cnt != 2) fill_cnt <= fill_cnt + 2'd1;
    end

    // R7: the synchronized value is the pin value from two edges earlier
    assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == 2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_split_ctrl.sv
module gpio_split_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*HALF_W-1:0] bus_wdata,
    output logic [2*HALF_W-1:0] bus_rdata,
    input  logic [2*HALF_W-1:0] pad_in,
    output logic [2*HALF_W-1:0] pad_oe,
    output logic [2*HALF_W-1:0] pad_out
);
    localparam int NUM_HALVES = 2;
    localparam int PIN_W      = NUM_HALVES * HALF_W;

    logic [HALF_W-1:0] dir_h [NUM_HALVES];
    logic [HALF_W-1:0] out_h [NUM_HALVES];
    logic [PIN_W-1:0]  pins_sync;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(OFS_DIR_LO) + ADDR_W'(h * HALF_STEP);
        localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(OFS_OUT_LO) + ADDR_W'(h * HALF_STEP);
        logic dir_we;
        logic out_we;
        assign dir_we = bus_wr && (bus_addr == DIR_A);
        assign out_we = bus_wr && (bus_addr == OUT_A);

        gpio_half_bank #(.HALF_W(HALF_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .dir_we (dir_we),
            .out_we (out_we),
            .wmask  (bus_wdata[PIN_W-1:HALF_W]),
            .wval   (bus_wdata[HALF_W-1:0]),
            .dir_q  (dir_h[h]),
            .out_q  (out_h[h])
        );

        assign pad_oe[h*HALF_W +: HALF_W]  = dir_h[h];
        assign pad_out[h*HALF_W +: HALF_W] = out_h[h] & dir_h[h];
    end

    gpio_in_sync #(.W(PIN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_OUT_LO): bus_rdata[HALF_W-1:0] = out_h[0];
            ADDR_W'(OFS_OUT_HI): bus_rdata[HALF_W-1:0] = out_h[1];
            ADDR_W'(OFS_DIR_LO): bus_rdata[HALF_W-1:0] = dir_h[0];
            ADDR_W'(OFS_DIR_HI): bus_rdata[HALF_W-1:0] = dir_h[1];
            ADDR_W'(OFS_PINS):   bus_rdata = pins_sync;
            default:             bus_rdata = '0;
        endcase
    end

    // R5: an output value never reaches a pin whose direction bit is 0
    assert_pad_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);
    // R6: register reads carry zeros in the upper half
    assert_read_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_DIR_LO) || bus_addr == ADDR_W'(OFS_DIR_HI) ||
         bus_addr == ADDR_W'(OFS_OUT_LO) || bus_addr == ADDR_W'(OFS_OUT_HI))
        |-> (bus_rdata[PIN_W-1:HALF_W] == '0));
    // R4: a write to the low-half addresses leaves the high-pin enables alone
    assert_half_isolation_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(OFS_DIR_LO) || bus_addr == ADDR_W'(OFS_OUT_LO)))
        |=> $stable(pad_oe[PIN_W-1:HALF_W]));
endmodule

// File: tb/gpio_split_ctrl_tb.sv
module gpio_split_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] m_dir = '0;
    logic [31:0] m_out = '0;

    always #2 clk = ~clk;

    gpio_split_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [15:0] merge(logic [15:0] cur, logic [31:0] w);
        return (cur & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        case (a)
            12'h100: m_out[15:0]  = merge(m_out[15:0], d);
            12'h104: m_out[31:16] = merge(m_out[31:16], d);
            12'h108: m_dir[15:0]  = merge(m_dir[15:0], d);
            12'h10C: m_dir[31:16] = merge(m_dir[31:16], d);
            default: ;
        endcase
    endtask

    task automatic read_check(string req, logic [11:0] a, logic [31:0] exp);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic check_all(string req);
        read_check({req, "/R6 out_lo"}, 12'h100, {16'h0, m_out[15:0]});
        read_check({req, "/R6 out_hi"}, 12'h104, {16'h0, m_out[31:16]});
        read_check({req, "/R6 dir_lo"}, 12'h108, {16'h0, m_dir[15:0]});
        read_check({req, "/R6 dir_hi"}, 12'h10C, {16'h0, m_dir[31:16]});
        check({req, "/R5 oe"}, pad_oe, m_dir);
        check({req, "/R5 out"}, pad_out, m_out & m_dir);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R2 directed: set selected low bits, then clear one
        bus_write(12'h108, 32'h00FF_00A5);
        check_all("R2 dir set");
        bus_write(12'h100, 32'h0003_FFFF);
        check_all("R2 out set");
        bus_write(12'h108, 32'h0001_0000);
        check_all("R2 dir clear bit0");

        // R3 zero mask
        bus_write(12'h108, 32'h0000_FFFF);
        check_all("R3 dir");
        bus_write(12'h104, 32'h0000_FFFF);
        check_all("R3 out_hi");

        // R4 halves independent
        bus_write(12'h10C, 32'hFFFF_F00F);
        check_all("R4 hi dir");
        bus_write(12'h108, 32'hFFFF_FFFF);
        check("R4 hi untouched", pad_oe[31:16], 16'hF00F);
        check_all("R4 lo dir");

        // R8 writes to input register and unmapped address
        bus_write(12'h010, 32'hFFFF_0000);
        check_all("R8 in reg write");
        bus_write(12'h110, 32'hFFFF_0000);
        check_all("R8 unmapped write");
        read_check("R8 unmapped read", 12'h200, 32'h0);

        // R7 two-flop input path
        pad_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        read_check("R7 steady", 12'h010, 32'h1234_5678);
        pad_in = 32'hCAFE_0001;
        @(negedge clk);
        read_check("R7 after one edge", 12'h010, 32'h1234_5678);
        @(negedge clk);
        read_check("R7 after two edges", 12'h010, 32'hCAFE_0001);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [11:0] a;
            r = $urandom;
            case ($urandom % 5)
                0: a = 12'h100;
                1: a = 12'h104;
                2: a = 12'h108;
                3: a = 12'h10C;
                default: a = 12'h010;
            endcase
            if ($urandom % 8 == 0) r[31:16] = '0;
            bus_write(a, r);
            check_all("R2 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule